// File: doc/BRIEF.md
# Flag-Only Subtract Compare Unit

This block sits beside the arithmetic path of a 32-bit processor core and evaluates comparisons between a destination operand and a source operand. It subtracts one operand from the other and keeps only two status flags, a zero flag and a carry flag. The difference itself is discarded. No result leaves the block, so the comparison never overwrites a register.

Three comparison flavours are offered.
- The plain compare subtracts source from destination.
- The swapped compare subtracts destination from source. Its carry therefore has the opposite sense of the plain compare.
- The rollover-safe compare reports whether the difference, destination minus source, is negative when read as a signed value. It suits deadlines on a free-running counter, because the answer stays correct across a counter wrap as long as the two values lie within 2^31 counts of each other.

A fourth select code does nothing.

Each flag has its own write enable. A comparison can therefore refresh only Z, only C, both flags or neither. Flags change only on a clock edge where the request strobe is high.

The design is built from three parts:
- a difference stage that orders the operands and derives both candidate flags;
- a decode stage inside the top module that turns the select code and the enables into per-flag update strobes;
- a two-bit flag register.

Top module: `cmp_flag_unit`

## Requirements
- R1: While `rst_n` is low, both `z_o` and `c_o` are 0 after the next clock edge.
- R2: Select code 2'b00 (plain): the Z result is 1 exactly when D equals S. The C result is 1 exactly when D < S as unsigned numbers, which is the borrow of D − S.
- R3: Select code 2'b01 (swapped): the Z result is 1 exactly when S − D is zero. The C result is 1 exactly when S < D as unsigned numbers, which is the borrow of S − D.
- R4: Select code 2'b10 (rollover-safe): the Z result is 1 exactly when D − S is zero. The C result equals bit 31 of the 32-bit difference D − S.
- R5: Select code 2'b11 leaves both flags unchanged, whatever the enables and operands are.
- R6: An edge where `valid_i` is low leaves both flags unchanged.
- R7: `z_o` takes the new Z result only on an edge where `valid_i` and `wz_i` are both high. With `wz_i` low, `z_o` keeps its value.
- R8: `c_o` takes the new C result only on an edge where `valid_i` and `wc_i` are both high. With `wc_i` low, `c_o` keeps its value.
- R9: The rollover-safe compare gives the correct ordering across a counter wrap. With D = 32'h0000_0005 and S = 32'hFFFF_FFFE it yields C = 0. With the operands exchanged it yields C = 1.
- R10: Flag results are registered: they appear on `z_o` and `c_o` one clock edge after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Request strobe for this cycle |
| op_i | input | 2 | Compare select: 00 plain, 01 swapped, 10 rollover-safe, 11 none |
| d_i | input | 32 | Destination operand |
| s_i | input | 32 | Source operand |
| wz_i | input | 1 | Allow Z update |
| wc_i | input | 1 | Allow C update |
| z_o | output | 1 | Registered zero flag |
| c_o | output | 1 | Registered carry flag |

## Verification
The bench drives operand pairs that are equal, that differ by one in each direction, and that straddle the counter wrap. These cases catch a design that swaps the operands of the swapped compare, or that uses the unsigned borrow in place of the sign bit for the rollover-safe compare. Either mistake inverts C exactly on the pairs next to a wrap or next to equality.

Random requests mix the idle select code, a low strobe and one enable held low with the other high. A design that decodes the idle code as a compare, or that shares one enable between both flags, would then move a flag that should have held.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'b00,
        OP_SWAP  = 2'b01,
        OP_WRAP  = 2'b10,
        OP_IDLE  = 2'b11
    } cmp_op_e;

endpackage

// File: rtl/cmpu_diff.sv
module cmpu_diff
    import cmpu_pkg::*;
#(
    parameter int W = 32
) (
    input  cmp_op_e      op,
    input  logic [W-1:0] d,
    input  logic [W-1:0] s,
    output logic         z_n,
    output logic         c_n
);
    localparam int MSB = W - 1;

    logic [W-1:0] lhs;
    logic [W-1:0] rhs;
    logic [W-1:0] dif;
    logic         brw;

    // Operand ordering per compare flavour.
    always_comb begin
        unique case (op)
            OP_SWAP: begin
                lhs = s;
                rhs = d;
            end
            OP_PLAIN, OP_WRAP, OP_IDLE: begin
                lhs = d;
                rhs = s;
            end
            default: begin
                lhs = d;
                rhs = s;
            end
        endcase
    end

    // One subtractor; the extra top bit is the unsigned borrow.
    always_comb begin
        {brw, dif} = {1'b0, lhs} - {1'b0, rhs};
    end

    // Carry source selection: sign of difference or borrow.
    always_comb begin
        z_n = (dif == '0);
        unique case (op)
            OP_WRAP: c_n = dif[MSB];
            OP_PLAIN, OP_SWAP, OP_IDLE: c_n = brw;
            default: c_n = brw;
        endcase
    end

endmodule

// File: rtl/cmpu_flag_reg.sv
module cmpu_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_z,
    input  logic upd_c,
    input  logic z_n,
    input  logic c_n,
    output logic z_q,
    output logic c_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else begin
            if (upd_z) z_q <= z_n;
            if (upd_c) c_q <= c_n;
        end
    end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] s_i,
    input  logic         wz_i,
    input  logic         wc_i,
    output logic         z_o,
    output logic         c_o
);

    cmp_op_e op;
    logic    op_live;
    logic    z_n;
    logic    c_n;
    logic    upd_z;
    logic    upd_c;

    assign op = cmp_op_e'(op_i);

    // Decode: the idle code never counts as a compare.
    always_comb begin
        unique case (op)
            OP_PLAIN, OP_SWAP, OP_WRAP: op_live = 1'b1;
            OP_IDLE: op_live = 1'b0;
            default: op_live = 1'b0;
        endcase
        upd_z = valid_i & op_live & wz_i;
        upd_c = valid_i & op_live & wc_i;
    end

    cmpu_diff #(.W(W)) u_diff (
        .op  (op),
        .d   (d_i),
        .s   (s_i),
        .z_n (z_n),
        .c_n (c_n)
    );

    cmpu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_z (upd_z),
        .upd_c (upd_c),
        .z_n   (z_n),
        .c_n   (c_n),
        .z_q   (z_o),
        .c_q   (c_o)
    );

endmodule

// File: rtl/cmpu_chk.sv
module cmpu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_i,
    input logic [1:0]   op_i,
    input logic [W-1:0] d_i,
    input logic [W-1:0] s_i,
    input logic         wz_i,
    input logic         wc_i,
    input logic         z_o,
    input logic         c_o
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!z_o && !c_o));

    // R2
    plain_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'b00 && wc_i) |=> (c_o == $past(d_i < s_i)));

    // R3
    swap_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'b01 && wc_i) |=> (c_o == $past(s_i < d_i)));

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'b10 && wz_i) |=> (z_o == $past(d_i == s_i)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'b11) |=> ($stable(z_o) && $stable(c_o)));

    // R6
    novalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(z_o) && $stable(c_o)));

    // R7
    z_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wz_i |=> $stable(z_o));

    // R8
    c_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wc_i |=> $stable(c_o));

endmodule

bind cmp_flag_unit cmpu_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .op_i    (op_i),
    .d_i     (d_i),
    .s_i     (s_i),
    .wz_i    (wz_i),
    .wc_i    (wc_i),
    .z_o     (z_o),
    .c_o     (c_o)
);

// File: tb/tb_cmp_flag_unit.sv
`timescale 1ns/1ps
module tb_cmp_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  op_i = 2'b11;
    logic [31:0] d_i = '0;
    logic [31:0] s_i = '0;
    logic        wz_i = 1'b0;
    logic        wc_i = 1'b0;
    logic        z_o;
    logic        c_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic exp_z = 1'b0;
    logic exp_c = 1'b0;

    always #2 clk = ~clk;

    cmp_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .d_i(d_i), .s_i(s_i), .wz_i(wz_i), .wc_i(wc_i),
        .z_o(z_o), .c_o(c_o)
    );

    function automatic logic ref_z(input logic [1:0] op, input logic [31:0] d, input logic [31:0] s);
        return (d == s);
    endfunction

    function automatic logic ref_c(input logic [1:0] op, input logic [31:0] d, input logic [31:0] s);
        logic [31:0] t;
        case (op)
            2'b00: return (d < s);
            2'b01: return (s < d);
            default: begin
                t = d - s;
                return t[31];
            end
        endcase
    endfunction

    function automatic string tag(input logic [1:0] op, input logic v, input logic wz, input logic wc);
        if (!v) return "R6";
        if (op == 2'b11) return "R5";
        if (!wz || !wc) return "R7/R8";
        case (op)
            2'b00: return "R2";
            2'b01: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic az, input logic ac,
                         input logic ez, input logic ec);
        checks++;
        if (az !== ez || ac !== ec) begin
            errors++;
            $display("FAIL %s: z=%b c=%b expected z=%b c=%b", req, az, ac, ez, ec);
        end
    endtask

    // Drive at the falling edge, sample just after the next rising edge (R10).
    task automatic req(input logic v, input logic [1:0] op, input logic [31:0] d,
                       input logic [31:0] s, input logic wz, input logic wc,
                       input string name);
        @(negedge clk);
        valid_i = v; op_i = op; d_i = d; s_i = s; wz_i = wz; wc_i = wc;
        @(posedge clk);
        #1;
        if (v && op != 2'b11) begin
            if (wz) exp_z = ref_z(op, d, s);
            if (wc) exp_c = ref_c(op, d, s);
        end
        check(name, z_o, c_o, exp_z, exp_c);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rs;
        rs = $urandom(32'd7);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", z_o, c_o, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 plain
        req(1, 2'b00, 32'd10, 32'd10, 1, 1, "R2 equal");
        req(1, 2'b00, 32'd9,  32'd10, 1, 1, "R2 d<s");
        req(1, 2'b00, 32'd11, 32'd10, 1, 1, "R2 d>s");
        // R3 swapped
        req(1, 2'b01, 32'd9,  32'd10, 1, 1, "R3 d<s");
        req(1, 2'b01, 32'd11, 32'd10, 1, 1, "R3 d>s");
        req(1, 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, "R3 equal");
        // R4 / R9 rollover
        req(1, 2'b10, 32'h0000_0005, 32'hFFFF_FFFE, 1, 1, "R9 wrap ahead");
        check("R9 C=0", 1'b0, c_o, 1'b0, 1'b0);
        req(1, 2'b10, 32'hFFFF_FFFE, 32'h0000_0005, 1, 1, "R9 wrap behind");
        check("R9 C=1", 1'b0, c_o, 1'b0, 1'b1);
        req(1, 2'b10, 32'h8000_0000, 32'h0000_0000, 1, 1, "R4 half range");
        // R5 idle with flags at known state
        req(1, 2'b00, 32'd1, 32'd1, 1, 1, "R2 set z");
        req(1, 2'b11, 32'd0, 32'd5, 1, 1, "R5 idle");
        // R6 strobe low
        req(0, 2'b00, 32'd0, 32'd5, 1, 1, "R6 novalid");
        // R7 / R8 single enables
        req(1, 2'b00, 32'd0, 32'd5, 0, 1, "R7 z held");
        req(1, 2'b00, 32'd7, 32'd7, 1, 0, "R8 c held");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            logic [1:0] op;
            logic v, wz, wc;
            a = $urandom;
            case ($urandom % 4)
                0: b = a;
                1: b = a + 32'd1;
                2: b = a - 32'd1;
                default: b = $urandom;
            endcase
            op = 2'($urandom);
            v  = ($urandom % 8) != 0;
            wz = ($urandom % 4) != 0;
            wc = ($urandom % 4) != 0;
            req(v, op, a, b, wz, wc, tag(op, v, wz, wc));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule